// File: doc/BRIEF.md
# Single-Wire Parity Byte Link

This block moves bytes across one shared data line that idles high through a pull-up. Each end drives the line only while it is sending. Every byte travels as a self-timed frame. First comes a low pulse one bit period long. The line then rises, and that rising edge marks the frame start. The line stays high for half a bit period, then carries eight data bits with the most significant bit first, then one even parity bit. After the parity bit the sender holds the line low, so the next frame's rising edge is always clean.

A packet sequencer sends or receives a run of bytes back to back. On the send side the block takes each byte from `tx_byte` and marks the capture with `tx_take`. On the receive side it arms the frame receiver once per byte and presents each byte on `rx_byte` with a one-cycle `rx_strobe`. The line input passes through a synchroniser. The bit period is the parameter `BIT_CYC`, given in system clock cycles. The default of 300 cycles gives a 6 µs bit at 50 MHz. Other presets such as 4, 12, 24, 36 or 48 µs are chosen by scaling `BIT_CYC`.

The sequencer has five states. SQ_IDLE waits for a go and moves to SQ_TX_ARM on `send_go` or to SQ_RX_ARM on `recv_go`; if both arrive together, `send_go` wins. SQ_TX_ARM starts one frame and moves to SQ_TX_WAIT. SQ_TX_WAIT returns to SQ_TX_ARM for the next byte, or to SQ_IDLE after the last. SQ_RX_ARM and SQ_RX_WAIT pair up the same way for receiving. The transmitter has seven states, in this order: TX_IDLE, TX_SYNC (low pulse), TX_MARK (half-period high), TX_DATA, TX_PAR, TX_TAIL (half-period low), then TX_HOLD or TX_IDLE. TX_HOLD keeps the line low until the next start; TX_IDLE releases it. The receiver has four states: RX_IDLE, RX_SEEK_LO (wait for low, with a timeout), RX_SEEK_HI (wait for the rise) and RX_SAMPLE (nine mid-bit samples), after which it returns to RX_IDLE.

Top module: `swc_codec`

## Requirements
- R1: When a byte is sent from idle, `line_oe` rises with `line_out` at 0. The line then stays low for exactly `BIT_CYC` cycles and is driven high for `BIT_CYC/2` cycles; that rising edge starts the frame.
- R2: The eight data bits follow the high half-period, most significant bit first, and each bit is held for `BIT_CYC` cycles.
- R3: The ninth bit of a frame is even parity, the XOR of the eight data bits.
- R4: After the parity bit the line is driven low. Between bytes of a packet it stays low until the next sync rise. After the last byte it stays low for `BIT_CYC/2` cycles, then `line_oe` drops, and `line_oe` stays low whenever `busy` is low.
- R5: Once armed, the receiver waits for the synchronised line to go low and then high. It samples the first bit `BIT_CYC` cycles after the rise and each later bit `BIT_CYC` cycles after the one before. It shows the byte on `rx_byte`, most significant bit first, with a one-cycle `rx_strobe`.
- R6: If the line stays high for `5*BIT_CYC` cycles after the receiver is armed, sampling starts as though a rising edge had occurred at that moment. An undriven line therefore yields 0xFF with a parity error.
- R7: `rx_perr` is 1 together with `rx_strobe` when the sampled parity bit differs from the XOR of the sampled data bits.
- R8: `pkt_len` holds the byte count minus one. `pkt_done` is a one-cycle pulse that coincides with `busy` low. `pkt_good` is 1 after a sent packet. After a received packet it is 1 only if no byte in that packet had a parity error.
- R9: `tx_take` pulses for one cycle for each byte sent, in the cycle that `tx_byte` is captured, and never together with `rx_strobe`. The next byte must be on `tx_byte` from the cycle after the pulse.
- R10: `send_go` and `recv_go` have no effect while `busy` is 1.
- R11: In reset, `line_oe`, `busy`, `pkt_done`, `pkt_good`, `rx_strobe` and `tx_take` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level read back from the shared line |
| line_oe | output | 1 | 1 while this end drives the line |
| line_out | output | 1 | Level driven when `line_oe` is 1 |
| send_go | input | 1 | Starts a send packet |
| recv_go | input | 1 | Starts a receive packet |
| pkt_len | input | LEN_W | Bytes in the packet minus one |
| tx_byte | input | 8 | Byte offered for sending |
| tx_take | output | 1 | `tx_byte` is captured this cycle |
| rx_byte | output | 8 | Last byte received |
| rx_strobe | output | 1 | `rx_byte` and `rx_perr` are new |
| rx_perr | output | 1 | Parity mismatch on the last byte |
| busy | output | 1 | A packet is in progress |
| pkt_done | output | 1 | Packet finished (one cycle) |
| pkt_good | output | 1 | Last packet had no parity error |

## Verification
A transmitter state that advances on the wrong count shows up at once on the line. The sync low would measure other than `BIT_CYC`, or a mid-bit sample would land in the neighbouring bit, so the first byte decodes wrongly within about eleven bit periods. A wrong receiver count or a wrong parity accumulator shows as a wrong `rx_byte` or `rx_perr` at the next `rx_strobe`. A wrong timeout shows as a shifted strobe time on an undriven line. A sequencer that loses its byte count or its error flag shows at packet end as an extra or missing `tx_take`, or as a wrong `pkt_good` one cycle after the last strobe.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SYNC,
        TX_MARK,
        TX_DATA,
        TX_PAR,
        TX_TAIL,
        TX_HOLD
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SEEK_LO,
        RX_SEEK_HI,
        RX_SAMPLE
    } rx_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_TX_ARM,
        SQ_TX_WAIT,
        SQ_RX_ARM,
        SQ_RX_WAIT
    } seq_state_e;

endpackage

// File: rtl/swc_tx_frame.sv
module swc_tx_frame
    import swc_pkg::*;
#(
    parameter int BIT_CYC = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    input  logic       chain,
    output logic       drv_en,
    output logic       drv_val,
    output logic       done
);
    localparam int HALF = BIT_CYC / 2;
    localparam int CW   = $clog2(BIT_CYC);
    localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CYC - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

    tx_state_e     state, nxt;
    logic [CW-1:0] cnt;
    logic [7:0]    shreg;
    logic          par;
    logic [2:0]    bidx;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            shreg <= '0;
            par   <= 1'b0;
            bidx  <= '0;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= 1'b0;
            unique case (state)
                TX_IDLE, TX_HOLD: begin
                    if (start) begin
                        shreg <= data;
                        par   <= 1'b0;
                        cnt   <= '0;
                        bidx  <= '0;
                    end
                end
                TX_SYNC, TX_PAR: begin
                    cnt <= (cnt == BIT_LAST) ? '0 : cnt + 1'b1;
                end
                TX_MARK: begin
                    cnt <= (cnt == HALF_LAST) ? '0 : cnt + 1'b1;
                end
                TX_DATA: begin
                    if (cnt == BIT_LAST) begin
                        cnt   <= '0;
                        par   <= par ^ shreg[7];
                        shreg <= {shreg[6:0], 1'b0};
                        bidx  <= bidx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_TAIL: begin
                    if (cnt == HALF_LAST) begin
                        cnt  <= '0;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE, TX_HOLD: if (start) nxt = TX_SYNC;
            TX_SYNC: if (cnt == BIT_LAST) nxt = TX_MARK;
            TX_MARK: if (cnt == HALF_LAST) nxt = TX_DATA;
            TX_DATA: if (cnt == BIT_LAST && bidx == 3'd7) nxt = TX_PAR;
            TX_PAR:  if (cnt == BIT_LAST) nxt = TX_TAIL;
            TX_TAIL: if (cnt == HALF_LAST) nxt = chain ? TX_HOLD : TX_IDLE;
        endcase
    end

    // line outputs
    always_comb begin
        drv_en  = 1'b1;
        drv_val = 1'b0;
        unique case (state)
            TX_IDLE: begin drv_en = 1'b0; drv_val = 1'b1; end
            TX_SYNC: drv_val = 1'b0;
            TX_MARK: drv_val = 1'b1;
            TX_DATA: drv_val = shreg[7];
            TX_PAR:  drv_val = par;
            TX_TAIL, TX_HOLD: drv_val = 1'b0;
        endcase
    end

endmodule

// File: rtl/swc_rx_frame.sv
module swc_rx_frame
    import swc_pkg::*;
#(
    parameter int BIT_CYC = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       line,
    output logic [7:0] byte_q,
    output logic       perr,
    output logic       done
);
    localparam int TMO = 5 * BIT_CYC;
    localparam int CW  = $clog2(TMO);
    localparam logic [CW-1:0] TMO_LAST = CW'(TMO - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(BIT_CYC - 1);

    rx_state_e     state, nxt;
    logic [CW-1:0] cnt;
    logic [7:0]    shreg;
    logic          acc;
    logic [3:0]    bidx;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            acc    <= 1'b0;
            bidx   <= '0;
            byte_q <= '0;
            perr   <= 1'b0;
            done   <= 1'b0;
        end else begin
            state <= nxt;
            done  <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (start) begin
                        cnt  <= '0;
                        acc  <= 1'b0;
                        bidx <= '0;
                    end
                end
                RX_SEEK_LO: begin
                    if (!line || cnt == TMO_LAST) cnt <= '0;
                    else                          cnt <= cnt + 1'b1;
                end
                RX_SEEK_HI: cnt <= '0;
                RX_SAMPLE: begin
                    if (cnt == BIT_LAST) begin
                        cnt  <= '0;
                        bidx <= bidx + 1'b1;
                        if (bidx < 4'd8) begin
                            shreg <= {shreg[6:0], line};
                            acc   <= acc ^ line;
                        end else begin
                            byte_q <= shreg;
                            perr   <= acc ^ line;
                            done   <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:    if (start) nxt = RX_SEEK_LO;
            RX_SEEK_LO: begin
                if (!line)                 nxt = RX_SEEK_HI;
                else if (cnt == TMO_LAST)  nxt = RX_SAMPLE;
            end
            RX_SEEK_HI: if (line) nxt = RX_SAMPLE;
            RX_SAMPLE:  if (cnt == BIT_LAST && bidx == 4'd8) nxt = RX_IDLE;
        endcase
    end

endmodule

// File: rtl/swc_pkt_seq.sv
module swc_pkt_seq
    import swc_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send_go,
    input  logic             recv_go,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             tx_done,
    input  logic             rx_done,
    input  logic             rx_perr,
    output logic             tx_start,
    output logic             tx_chain,
    output logic             rx_start,
    output logic             busy,
    output logic             pkt_done,
    output logic             pkt_good
);
    seq_state_e       state, nxt;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic             err_q;
    logic             last;

    assign last = (cnt == len_q);

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            err_q    <= 1'b0;
            pkt_done <= 1'b0;
            pkt_good <= 1'b0;
        end else begin
            state    <= nxt;
            pkt_done <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (send_go || recv_go) begin
                        cnt   <= '0;
                        len_q <= pkt_len;
                        err_q <= 1'b0;
                    end
                end
                SQ_TX_ARM, SQ_RX_ARM: begin
                end
                SQ_TX_WAIT: begin
                    if (tx_done) begin
                        if (last) begin
                            pkt_done <= 1'b1;
                            pkt_good <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                SQ_RX_WAIT: begin
                    if (rx_done) begin
                        err_q <= err_q | rx_perr;
                        if (last) begin
                            pkt_done <= 1'b1;
                            pkt_good <= !(err_q | rx_perr);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE: begin
                if (send_go)      nxt = SQ_TX_ARM;
                else if (recv_go) nxt = SQ_RX_ARM;
            end
            SQ_TX_ARM:  nxt = SQ_TX_WAIT;
            SQ_TX_WAIT: if (tx_done) nxt = last ? SQ_IDLE : SQ_TX_ARM;
            SQ_RX_ARM:  nxt = SQ_RX_WAIT;
            SQ_RX_WAIT: if (rx_done) nxt = last ? SQ_IDLE : SQ_RX_ARM;
        endcase
    end

    // outputs
    always_comb begin
        tx_start = (state == SQ_TX_ARM);
        rx_start = (state == SQ_RX_ARM);
        tx_chain = !last;
        busy     = (state != SQ_IDLE);
    end

endmodule

// File: rtl/swc_codec.sv
module swc_codec #(
    parameter int BIT_CYC     = 300,
    parameter int LEN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic             line_oe,
    output logic             line_out,
    input  logic             send_go,
    input  logic             recv_go,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [7:0]       tx_byte,
    output logic             tx_take,
    output logic [7:0]       rx_byte,
    output logic             rx_strobe,
    output logic             rx_perr,
    output logic             busy,
    output logic             pkt_done,
    output logic             pkt_good
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;
    logic                   tx_start, tx_chain, tx_done, rx_start;

    // line synchroniser, idles at the pulled-up level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end
    assign line_s  = sync_q[SYNC_STAGES-1];
    assign tx_take = tx_start;

    swc_pkt_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .send_go  (send_go),
        .recv_go  (recv_go),
        .pkt_len  (pkt_len),
        .tx_done  (tx_done),
        .rx_done  (rx_strobe),
        .rx_perr  (rx_perr),
        .tx_start (tx_start),
        .tx_chain (tx_chain),
        .rx_start (rx_start),
        .busy     (busy),
        .pkt_done (pkt_done),
        .pkt_good (pkt_good)
    );

    swc_tx_frame #(.BIT_CYC(BIT_CYC)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .data    (tx_byte),
        .chain   (tx_chain),
        .drv_en  (line_oe),
        .drv_val (line_out),
        .done    (tx_done)
    );

    swc_rx_frame #(.BIT_CYC(BIT_CYC)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rx_start),
        .line   (line_s),
        .byte_q (rx_byte),
        .perr   (rx_perr),
        .done   (rx_strobe)
    );

endmodule

// File: rtl/swc_codec_chk.sv
module swc_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic line_oe,
    input logic line_out,
    input logic tx_take,
    input logic rx_strobe,
    input logic busy,
    input logic pkt_done
);
    AST_SYNC_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> !line_out);  // R1

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_oe);  // R4

    AST_RX_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> !line_oe);  // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);  // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> !busy);  // R8

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_take, rx_strobe}));  // R9

endmodule

bind swc_codec swc_codec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_oe   (line_oe),
    .line_out  (line_out),
    .tx_take   (tx_take),
    .rx_strobe (rx_strobe),
    .busy      (busy),
    .pkt_done  (pkt_done)
);

// File: tb/sim_swc_codec.sv
module sim_swc_codec;
    localparam int BIT   = 16;
    localparam int HALF  = BIT / 2;
    localparam int LEN_W = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic             send_go, recv_go;
    logic [LEN_W-1:0] pkt_len;
    logic [7:0]       tx_byte;
    logic             peer_drv, peer_val;
    logic             line;
    logic             line_oe, line_out, tx_take, rx_strobe, rx_perr;
    logic             busy, pkt_done, pkt_good;
    logic [7:0]       rx_byte;

    assign line = line_oe ? line_out : (peer_drv ? peer_val : 1'b1);

    swc_codec #(.BIT_CYC(BIT), .LEN_W(LEN_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line), .line_oe(line_oe),
        .line_out(line_out), .send_go(send_go), .recv_go(recv_go),
        .pkt_len(pkt_len), .tx_byte(tx_byte), .tx_take(tx_take),
        .rx_byte(rx_byte), .rx_strobe(rx_strobe), .rx_perr(rx_perr),
        .busy(busy), .pkt_done(pkt_done), .pkt_good(pkt_good)
    );

    int checks = 0;
    int errors = 0;
    int take_cnt = 0;
    int strobe_cnt = 0;
    logic [7:0] pat [0:7];

    always @(negedge clk) begin
        if (tx_take)   take_cnt++;
        if (rx_strobe) strobe_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // decode one frame from the line; returns at the parity mid-point
    task automatic decode_byte(output logic [7:0] b, output logic p, output int lowlen);
        b = '0;
        lowlen = 0;
        while (line !== 1'b0) @(negedge clk);
        while (line === 1'b0) begin
            lowlen++;
            @(negedge clk);
        end
        cyc(BIT);
        for (int k = 0; k < 8; k++) begin
            b = {b[6:0], line};
            cyc(BIT);
        end
        p = line;
    endtask

    // peer sender model
    task automatic send_frame(input logic [7:0] b, input bit bad);
        peer_drv = 1'b1;
        peer_val = 1'b0;
        cyc(BIT);
        peer_val = 1'b1;
        cyc(HALF);
        for (int k = 7; k >= 0; k--) begin
            peer_val = b[k];
            cyc(BIT);
        end
        peer_val = (^b) ^ bad;
        cyc(BIT);
        peer_val = 1'b0;
        cyc(HALF);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; send_go = 1'b0; recv_go = 1'b0; pkt_len = '0;
        tx_byte = '0; peer_drv = 1'b0; peer_val = 1'b1;
        cyc(5);
        chk(line_oe == 1'b0, "R11 line_oe", int'(line_oe), 0);
        chk(busy == 1'b0, "R11 busy", int'(busy), 0);
        chk(pkt_done == 1'b0 && pkt_good == 1'b0, "R11 done/good",
            int'({pkt_done, pkt_good}), 0);
        chk(rx_strobe == 1'b0 && tx_take == 1'b0, "R11 strobes",
            int'({rx_strobe, tx_take}), 0);
        rst_n = 1'b1;
        cyc(3);
    endtask

    task automatic t_tx_packet(input int n, input bit poke);
        int s0;
        s0 = strobe_cnt;
        take_cnt = 0;
        @(negedge clk);
        pkt_len = LEN_W'(n - 1);
        tx_byte = pat[0];
        send_go = 1'b1;
        @(negedge clk);
        send_go = 1'b0;
        fork
            begin
                for (int i = 1; i < n; i++) begin
                    while (!tx_take) @(negedge clk);
                    @(posedge clk);
                    #1 tx_byte = pat[i];
                    @(negedge clk);
                end
            end
            begin
                for (int i = 0; i < n; i++) begin
                    logic [7:0] b;
                    logic p;
                    int lw;
                    decode_byte(b, p, lw);
                    if (i == 0) chk(lw == BIT, "R1 sync low width", lw, BIT);
                    chk(b == pat[i], "R2 data byte", int'(b), int'(pat[i]));
                    chk(p == ^pat[i], "R3 parity bit", int'(p), int'(^pat[i]));
                    cyc(HALF + HALF / 2);
                    chk(line == 1'b0, "R4 low after parity", int'(line), 0);
                    if (poke && i == 0) begin
                        send_go = 1'b1;
                        recv_go = 1'b1;
                        cyc(1);
                        send_go = 1'b0;
                        recv_go = 1'b0;
                    end
                end
            end
        join
        for (int w = 0; w < 100 && busy; w++) @(negedge clk);
        chk(line_oe == 1'b0, "R4 released after packet", int'(line_oe), 0);
        chk(pkt_good == 1'b1, "R8 send good", int'(pkt_good), 1);
        chk(take_cnt == n, "R9 take count", take_cnt, n);
        if (poke) begin
            cyc(5);
            chk(busy == 1'b0, "R10 no restart", int'(busy), 0);
            chk(strobe_cnt == s0, "R10 no receive", strobe_cnt - s0, 0);
        end
    endtask

    task automatic t_rx_packet(input int n, input int bad_idx);
        @(negedge clk);
        pkt_len = LEN_W'(n - 1);
        recv_go = 1'b1;
        @(negedge clk);
        recv_go = 1'b0;
        fork
            begin
                for (int i = 0; i < n; i++) send_frame(pat[i], i == bad_idx);
                peer_drv = 1'b0;
            end
            begin
                for (int i = 0; i < n; i++) begin
                    while (!rx_strobe) @(negedge clk);
                    chk(rx_byte == pat[i], "R5 received byte", int'(rx_byte), int'(pat[i]));
                    chk(rx_perr == (i == bad_idx), "R7 parity flag",
                        int'(rx_perr), int'(i == bad_idx));
                    @(negedge clk);
                    if (i == n - 1) begin
                        chk(pkt_done == 1'b1, "R8 done pulse", int'(pkt_done), 1);
                        chk(pkt_good == (bad_idx < 0), "R8 receive good",
                            int'(pkt_good), int'(bad_idx < 0));
                    end
                end
            end
        join
        cyc(4);
    endtask

    task automatic t_rx_timeout();
        int w;
        peer_drv = 1'b0;
        @(negedge clk);
        pkt_len = '0;
        recv_go = 1'b1;
        @(negedge clk);
        recv_go = 1'b0;
        w = 0;
        while (!rx_strobe && w < 400) begin
            @(negedge clk);
            w++;
        end
        chk(w >= 215 && w <= 235, "R6 timeout strobe time", w, 225);
        chk(rx_byte == 8'hFF, "R6 undriven byte", int'(rx_byte), 255);
        chk(rx_perr == 1'b1, "R7 undriven parity", int'(rx_perr), 1);
        @(negedge clk);
        chk(pkt_done == 1'b1 && pkt_good == 1'b0, "R8 bad packet",
            int'({pkt_done, pkt_good}), 2);
        cyc(4);
    endtask

    initial begin
        t_reset();

        pat[0] = 8'hA5;
        t_tx_packet(1, 1'b0);

        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h3C;
        t_tx_packet(3, 1'b1);

        pat[0] = 8'h81; pat[1] = 8'h7E; pat[2] = 8'h00; pat[3] = 8'hC3;
        t_rx_packet(4, -1);

        pat[0] = 8'h55; pat[1] = 8'hAA; pat[2] = 8'h12;
        t_rx_packet(3, 1);

        t_rx_timeout();

        pat[0] = 8'h96; pat[1] = 8'h01;
        t_rx_packet(2, -1);

        pat[0] = 8'h6B;
        t_tx_packet(1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule